// File: doc/BRIEF.md
# Gated Receive Bit FIFO

This block gathers single received bits into a 16-entry serial FIFO. Each bit arrives with a one-cycle strobe from an upstream clock recovery stage. A bit is stored only when the selected start condition holds. The condition can be the external valid-data level, a sync-word match, always, or never. Stored bits leave one per read strobe, oldest first. The bit at the head is always present on the read data output.

A level interrupt is raised while the stored bit count is at or above a programmable threshold. It is also raised while a sticky overflow flag is set. An empty flag is provided. Dropping the FIFO enable clears everything. Re-asserting the fill enable empties the store and forces the sync detector to hunt for a fresh sync word.

Top module: `rx_bit_fifo`

## Requirements
- R1: After reset the count is 0, `empty` is 1, `ovf` is 0, `fifo_irq` is 0 and `rd_bit` is 0.
- R2: Bits are read in arrival order. `rd_bit` shows the oldest stored bit. Each `rd_stb` while not empty removes that bit one cycle later.
- R3: With `start_sel` = 2'b11 and both enables high, every strobed bit is stored.
- R4: With `start_sel` = 2'b00, a strobed bit is stored only if `valid_data` is high in the same cycle.
- R5: With `start_sel` = 2'b10, no bit is ever stored.
- R6: With `start_sel` = 2'b01, nothing is stored until the last 16 strobed bits equal `SYNC_WORD`, with the first received bit compared against the MSB. The bit that completes the match is not stored. Every later strobed bit is stored until `fill_en` is cleared.
- R7: While `fill_en` is low, no bit is stored. In the cycle after `fill_en` rises the FIFO is empty and the sync detector has lost any earlier match.
- R8: While `fifo_en` is low, the count and the stored content are cleared, `ovf` is cleared and no bit is stored.
- R9: `fifo_irq` is high while the count is at least `level`, where `level` 0 means 16. It is also high while `ovf` is set. A `level` of 1 therefore makes `fifo_irq` a not-empty indicator.
- R10: A bit accepted for storage while 16 bits are held and no read happens is dropped. The stored bits are kept and `ovf` is set. `ovf` stays set until a `status_rd` pulse clears it.
- R11: `empty` is high exactly when the count is 0. A read strobe while empty changes nothing, and `rd_bit` is then 0.
- R12: A write and a read in the same cycle both take effect and leave the count unchanged. This also holds when the FIFO is full, and `ovf` is not set in that case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_en | input | 1 | FIFO enable; low clears the FIFO |
| fill_en | input | 1 | Fill enable; a rising edge empties the FIFO and re-arms the sync detector |
| start_sel | input | 2 | Fill start: 00 valid-data, 01 sync word, 10 never, 11 always |
| level | input | 4 | Interrupt threshold in bits (0 means 16) |
| valid_data | input | 1 | Valid-data qualifier from the analog path |
| bit_in | input | 1 | Received bit |
| bit_stb | input | 1 | One-cycle strobe marking `bit_in` as a new bit |
| rd_stb | input | 1 | Read strobe; removes the head bit |
| status_rd | input | 1 | Status read pulse; clears `ovf` |
| rd_bit | output | 1 | Oldest stored bit (0 when empty) |
| bit_count | output | 5 | Number of stored bits |
| empty | output | 1 | High when no bits are stored |
| ovf | output | 1 | Sticky overflow flag |
| fifo_irq | output | 1 | Threshold or overflow interrupt |

## Verification
Storage gating is tried with every start-select code under the same strobed bit stream. A stream that stores in one mode and is blocked in another separates the four decodes. The sync case starts the stream with noise bits and then feeds the full sync word, which shows that the completing bit is not stored and that only later bits are kept. Disarm and re-arm then prove that a fresh match is needed. Threshold and overflow runs fill to exactly 16 bits and push one more, then read back the whole stored pattern; this separates the rule that drops the new bit from one that overwrites an old bit. Same-cycle read and write, at a partial fill and at full, shows whether full is judged before or after the read.

// File: rtl/rx_bit_fifo.sv
module rx_bit_fifo #(
  parameter int DEPTH = 16,
  parameter int SYNC_W = 16,
  parameter logic [SYNC_W-1:0] SYNC_WORD = 16'hA5C3,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int LW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          fill_en,
  input  logic [1:0]    start_sel,
  input  logic [LW-1:0] level,
  input  logic          valid_data,
  input  logic          bit_in,
  input  logic          bit_stb,
  input  logic          rd_stb,
  input  logic          status_rd,
  output logic          rd_bit,
  output logic [CW-1:0] bit_count,
  output logic          empty,
  output logic          ovf,
  output logic          fifo_irq
);

  logic [DEPTH-1:0]  mem, mem_nx;
  logic [CW-1:0]     cnt;
  logic [SYNC_W-1:0] shreg;
  logic              armed, fill_q;
  logic              flush, fill_ok, cond, wr_req, wr_ok, rd_fire, ovf_hit;
  logic [CW-1:0]     wr_idx, thr;

  assign flush   = fill_en && !fill_q;
  assign fill_ok = fifo_en && fill_en && !flush;
  assign rd_fire = fifo_en && rd_stb && (cnt != '0);

  always_comb begin
    case (start_sel)
      2'b00:   cond = valid_data;
      2'b01:   cond = armed;
      2'b11:   cond = 1'b1;
      default: cond = 1'b0;
    endcase
  end

  assign wr_req  = bit_stb && fill_ok && cond;
  assign wr_ok   = wr_req && ((cnt != CW'(DEPTH)) || rd_fire);
  assign ovf_hit = wr_req && !wr_ok;
  assign wr_idx  = rd_fire ? cnt - 1'b1 : cnt;

  always_comb begin
    mem_nx = rd_fire ? {1'b0, mem[DEPTH-1:1]} : mem;
    for (int i = 0; i < DEPTH; i++)
      if (wr_ok && wr_idx == CW'(i)) mem_nx[i] = bit_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem <= '0;
      cnt <= '0;
      ovf <= 1'b0;
      fill_q <= 1'b0;
    end else begin
      fill_q <= fill_en;
      if (!fifo_en || flush) begin
        mem <= '0;
        cnt <= '0;
        if (!fifo_en) ovf <= 1'b0;
        else if (status_rd) ovf <= 1'b0;
      end else begin
        mem <= mem_nx;
        cnt <= cnt + CW'(wr_ok) - CW'(rd_fire);
        if (ovf_hit) ovf <= 1'b1;
        else if (status_rd) ovf <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      armed <= 1'b0;
    end else if (!fifo_en || !fill_en || flush) begin
      shreg <= '0;
      armed <= 1'b0;
    end else if (bit_stb) begin
      shreg <= {shreg[SYNC_W-2:0], bit_in};
      if ({shreg[SYNC_W-2:0], bit_in} == SYNC_WORD) armed <= 1'b1;
    end
  end

  assign thr       = (level == '0) ? CW'(DEPTH) : CW'(level);
  assign bit_count = cnt;
  assign empty     = (cnt == '0);
  assign rd_bit    = empty ? 1'b0 : mem[0];
  assign fifo_irq  = (cnt >= thr) || ovf;

  // R10
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && !flush && bit_stb && fill_en && cond && cnt == CW'(DEPTH) && !rd_stb) |=> (ovf && cnt == CW'(DEPTH)));

  // R10
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH));

  // R8
  disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |=> (empty && !ovf));

  // R5
  reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_sel == 2'b10) |=> (bit_count <= $past(bit_count)));

  // R9
  ovf_irq_chk: assert property (@(posedge clk) disable iff (!rst_n) ovf |-> fifo_irq);

  // R12
  simul_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && rd_fire && fill_ok) |=> (bit_count == $past(bit_count) && !$rose(ovf)));

  // R11
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !(bit_stb && fill_ok && cond)) |=> empty);

endmodule

// File: tb/test_rx_bit_fifo.sv
module test_rx_bit_fifo;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_en = 1'b0, fill_en = 1'b0, valid_data = 1'b0;
  logic bit_in = 1'b0, bit_stb = 1'b0, rd_stb = 1'b0, status_rd = 1'b0;
  logic [1:0] start_sel = 2'b11;
  logic [3:0] level = 4'd1;
  logic rd_bit, empty, ovf, fifo_irq;
  logic [4:0] bit_count;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  localparam logic [15:0] SW = 16'hA5C3;

  always #2 clk = ~clk;

  rx_bit_fifo i_rx_bit_fifo (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .fill_en(fill_en),
    .start_sel(start_sel), .level(level), .valid_data(valid_data),
    .bit_in(bit_in), .bit_stb(bit_stb), .rd_stb(rd_stb), .status_rd(status_rd),
    .rd_bit(rd_bit), .bit_count(bit_count), .empty(empty), .ovf(ovf),
    .fifo_irq(fifo_irq));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic b);
    @(negedge clk); bit_in = b; bit_stb = 1'b1;
    @(negedge clk); bit_stb = 1'b0;
  endtask

  task automatic rd(input string req, input logic exp);
    chk(req, rd_bit, exp);
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
  endtask

  task automatic drain;
    while (!empty) begin
      @(negedge clk); rd_stb = 1'b1;
      @(negedge clk); rd_stb = 1'b0;
    end
  endtask

  task automatic t_reset;
    chk("R1 count", bit_count, 0);
    chk("R1 empty", empty, 1);
    chk("R1 ovf", ovf, 0);
    chk("R1 irq", fifo_irq, 0);
    chk("R1 rd_bit", rd_bit, 0);
  endtask

  task automatic t_always;
    start_sel = 2'b11;
    wr(1); wr(0); wr(1); wr(1);
    chk("R3 count", bit_count, 4);
    rd("R2 b0", 1); rd("R2 b1", 0); rd("R2 b2", 1); rd("R2 b3", 1);
    chk("R11 empty", empty, 1);
  endtask

  task automatic t_valid;
    start_sel = 2'b00; valid_data = 1'b0;
    wr(1); wr(1); wr(0);
    chk("R4 blocked", bit_count, 0);
    valid_data = 1'b1;
    wr(0); wr(1);
    chk("R4 stored", bit_count, 2);
    rd("R4 b0", 0); rd("R4 b1", 1);
    valid_data = 1'b0;
  endtask

  task automatic t_reserved;
    start_sel = 2'b10;
    for (int i = 0; i < 5; i++) wr(1);
    chk("R5 count", bit_count, 0);
  endtask

  task automatic t_sync;
    start_sel = 2'b01;
    wr(1); wr(1); wr(1);
    for (int i = 15; i >= 0; i--) wr(SW[i]);
    chk("R6 completing bit not stored", bit_count, 0);
    wr(1); wr(0);
    chk("R6 after sync", bit_count, 2);
    rd("R6 b0", 1);
    wr(1);
    @(negedge clk); fill_en = 1'b0;
    wr(1);
    chk("R7 fill_en low blocks", bit_count, 2);
    @(negedge clk); fill_en = 1'b1;
    @(negedge clk);
    chk("R7 rise flushes", bit_count, 0);
    wr(1); wr(0);
    chk("R6 re-arm needed", bit_count, 0);
  endtask

  task automatic t_thresh;
    start_sel = 2'b11; level = 4'd3;
    wr(1); wr(0);
    chk("R9 below level", fifo_irq, 0);
    wr(1);
    chk("R9 at level", fifo_irq, 1);
    rd("R9 b0", 1);
    chk("R9 after read", fifo_irq, 0);
    drain();
    level = 4'd1;
    @(negedge clk);
    chk("R9 level1 empty", fifo_irq, 0);
    wr(0);
    chk("R9 level1 not-empty", fifo_irq, 1);
    drain();
  endtask

  task automatic t_overflow;
    logic [15:0] pat = 16'hC96B;
    level = 4'd0; start_sel = 2'b11;
    for (int i = 15; i >= 1; i--) wr(pat[i]);
    chk("R9 level0 at 15", fifo_irq, 0);
    wr(pat[0]);
    chk("R9 level0 at 16", fifo_irq, 1);
    chk("R10 no ovf yet", ovf, 0);
    wr(~pat[15]);
    chk("R10 ovf set", ovf, 1);
    chk("R10 count kept", bit_count, 16);
    @(negedge clk); status_rd = 1'b1;
    @(negedge clk); status_rd = 1'b0;
    chk("R10 ovf cleared", ovf, 0);
    for (int i = 15; i >= 0; i--) rd("R10 kept bits", pat[i]);
    chk("R11 empty after drain", empty, 1);
    level = 4'd1;
  endtask

  task automatic t_simul;
    start_sel = 2'b11;
    wr(1); wr(0);
    @(negedge clk); bit_in = 1'b1; bit_stb = 1'b1; rd_stb = 1'b1;
    @(negedge clk); bit_stb = 1'b0; rd_stb = 1'b0;
    chk("R12 count", bit_count, 2);
    rd("R12 b0", 0); rd("R12 b1", 1);
    for (int i = 0; i < 16; i++) wr(i[0]);
    @(negedge clk); bit_in = 1'b1; bit_stb = 1'b1; rd_stb = 1'b1;
    @(negedge clk); bit_stb = 1'b0; rd_stb = 1'b0;
    chk("R12 full count", bit_count, 16);
    chk("R12 full no ovf", ovf, 0);
    for (int i = 1; i < 16; i++) rd("R12 full order", i[0]);
    rd("R12 full last", 1);
  endtask

  task automatic t_disable;
    start_sel = 2'b11; level = 4'd0;
    for (int i = 0; i < 17; i++) wr(1);
    chk("R10 ovf before disable", ovf, 1);
    @(negedge clk); fifo_en = 1'b0;
    @(negedge clk);
    chk("R8 count", bit_count, 0);
    chk("R8 ovf", ovf, 0);
    wr(1);
    chk("R8 no store", bit_count, 0);
    @(negedge clk); fifo_en = 1'b1; level = 4'd1;
    wr(0);
    rd("R8 content cleared", 0);
  endtask

  task automatic t_empty_read;
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
    chk("R11 read empty count", bit_count, 0);
    chk("R11 read empty bit", rd_bit, 0);
    chk("R11 empty flag", empty, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk); fifo_en = 1'b1; fill_en = 1'b1;
    @(negedge clk);
    t_always();
    t_valid();
    t_reserved();
    t_sync();
    t_thresh();
    t_overflow();
    t_simul();
    t_disable();
    t_empty_read();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule